// File: doc/BRIEF.md
# Signed Logarithmic Multiply and Power Unit

This block operates on numbers held in sign-logarithm form: each value is a sign bit, a zero marker and a two's-complement fixed-point base-2 logarithm of its magnitude. Because a product in this form is a sum of logarithms, the block performs multiply, divide, square, reciprocal and square root without any array multiplier. Each operation is an add, a subtract, a one-bit shift or a negation of the log field, and the sign is resolved with an XOR or taken from the first operand.

An opcode picks the operation each cycle. The two operands arrive on parallel ports. The result sign, zero marker, log field and two flags come out of a single output register. The overflow flag marks a clamped or undefined result. The invalid flag marks a square root taken of a negative value. Conversion to and from linear values, and addition and subtraction in the log domain, are left to neighbouring blocks.

Top module: `slns_mpu`

## Requirements
- R1: The log field is LOG_W = 20 bits of two's complement with FRAC_W = 12 fraction bits. Every result is registered and appears one clock after its inputs are sampled, and it holds until the next edge. An active-low asynchronous reset clears every output to 0.
- R2: Opcode 0 (multiply) with both zero markers clear gives a log field equal to the sum of the operand log fields and a sign equal to a_sgn XOR b_sgn.
- R3: Opcode 1 (divide) with both zero markers clear gives a log field equal to a_log minus b_log and a sign equal to a_sgn XOR b_sgn.
- R4: Opcode 2 (square) with a_zero clear gives twice a_log (a left shift by one) and sign 0.
- R5: Opcode 3 (reciprocal) with a_zero clear gives the two's-complement negation of a_log and keeps a_sgn as the sign.
- R6: Opcode 4 (square root) with a_zero clear gives a_log shifted right arithmetically by one (rounding toward minus infinity) and sign 0. The invalid flag equals a_sgn. Overflow never occurs.
- R7: A result that falls outside the 20-bit signed range is clamped and raises the overflow flag. Too-large results become 0x7FFFF and too-small results become 0x80000.
- R8: A zero result gives res_zero=1 with log 0, sign 0, overflow 0 and invalid 0. This happens for multiply when either zero marker is set, for divide when only a_zero is set, and for square or square root when a_zero is set.
- R9: Divide with b_zero set, and reciprocal with a_zero set, give res_zero=0, log 0x7FFFF and overflow 1. The sign is a_sgn XOR b_sgn for divide and a_sgn for reciprocal.
- R10: Opcodes 5 to 7 pass operand A (sign, zero marker, log) through unchanged, with both flags 0.
- R11: Square, reciprocal, square root and pass-through ignore every operand B field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation select |
| a_sgn | input | 1 | Operand A sign (1 = negative) |
| a_zero | input | 1 | Operand A is zero |
| a_log | input | LOG_W | Operand A log magnitude |
| b_sgn | input | 1 | Operand B sign |
| b_zero | input | 1 | Operand B is zero |
| b_log | input | LOG_W | Operand B log magnitude |
| res_sgn | output | 1 | Result sign |
| res_zero | output | 1 | Result is zero |
| res_log | output | LOG_W | Result log magnitude |
| res_ovf | output | 1 | Result clamped or division by zero |
| res_inv | output | 1 | Square root of a negative operand |

## Verification
Every result is due exactly one rising edge after its operands and opcode are applied. The bench drives inputs on a falling edge and compares all outputs on the next falling edge, so exactly one register stage lies between stimulus and check. One check drives new operands and samples just before the rising edge, which confirms that the outputs still hold the previous result. The operand sweep pairs sixteen boundary log values under all eight opcodes, with signs and zero markers rotating through the sweep. Expected values come from integer arithmetic in the bench.

// File: rtl/slns_pkg.sv
package slns_pkg;

   typedef enum logic [2:0] {
      OP_MUL  = 3'd0,
      OP_DIV  = 3'd1,
      OP_SQR  = 3'd2,
      OP_RCP  = 3'd3,
      OP_SQRT = 3'd4
   } slns_op_e;

   typedef struct packed {
      logic sgn;
      logic zero;
      logic ovf;
      logic inv;
   } slns_flags_t;

endpackage

// File: rtl/slns_addsub.sv
module slns_addsub #(
   parameter int W   = 20,
   parameter bit SUB = 1'b0
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic [W-1:0] r,
   output logic         ovf
);
   localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

   logic [W:0] ext;

   generate
      if (SUB) begin : g_sub
         assign ext = {x[W-1], x} - {y[W-1], y};
      end else begin : g_add
         assign ext = {x[W-1], x} + {y[W-1], y};
      end
   endgenerate

   always_comb begin
      ovf = ext[W] ^ ext[W-1];
      if (!ovf)        r = ext[W-1:0];
      else if (ext[W]) r = MINV;
      else             r = MAXV;
   end
endmodule

// File: rtl/slns_unary.sv
module slns_unary #(
   parameter int W = 20
) (
   input  logic [W-1:0] x,
   output logic [W-1:0] dbl,
   output logic         dbl_ovf,
   output logic [W-1:0] neg,
   output logic         neg_ovf,
   output logic [W-1:0] half
);
   localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

   // doubling leaves range when the top two bits disagree
   assign dbl_ovf = x[W-1] ^ x[W-2];
   assign dbl     = dbl_ovf ? (x[W-1] ? MINV : MAXV) : {x[W-2:0], 1'b0};

   // only the most negative code has no positive counterpart
   assign neg_ovf = (x == MINV);
   assign neg     = neg_ovf ? MAXV : (W'(0) - x);

   assign half    = {x[W-1], x[W-1:1]};
endmodule

// File: rtl/slns_mpu.sv
module slns_mpu #(
   parameter int LOG_W   = 20,
   parameter int FRAC_W  = 12,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       op_i,
   input  logic             a_sgn,
   input  logic             a_zero,
   input  logic [LOG_W-1:0] a_log,
   input  logic             b_sgn,
   input  logic             b_zero,
   input  logic [LOG_W-1:0] b_log,
   output logic             res_sgn,
   output logic             res_zero,
   output logic [LOG_W-1:0] res_log,
   output logic             res_ovf,
   output logic             res_inv
);
   import slns_pkg::*;

   localparam logic [LOG_W-1:0] MAXV = {1'b0, {(LOG_W-1){1'b1}}};

   initial begin
      assert (LOG_W >= 4) else $error("slns_mpu: LOG_W must be at least 4");
      assert (FRAC_W >= 0 && FRAC_W < LOG_W)
         else $error("slns_mpu: FRAC_W must lie below LOG_W");
   end

   slns_op_e op;
   assign op = slns_op_e'(op_i);

   logic [LOG_W-1:0] sum_log, dif_log, dbl_log, neg_log, half_log;
   logic             sum_ovf, dif_ovf, dbl_ovf, neg_ovf;

   slns_addsub #(.W(LOG_W), .SUB(1'b0)) u_add (
      .x(a_log), .y(b_log), .r(sum_log), .ovf(sum_ovf));

   slns_addsub #(.W(LOG_W), .SUB(1'b1)) u_sub (
      .x(a_log), .y(b_log), .r(dif_log), .ovf(dif_ovf));

   slns_unary #(.W(LOG_W)) u_una (
      .x(a_log), .dbl(dbl_log), .dbl_ovf(dbl_ovf),
      .neg(neg_log), .neg_ovf(neg_ovf), .half(half_log));

   slns_flags_t      nx_f;
   logic [LOG_W-1:0] nx_log;

   always_comb begin
      nx_f   = '0;
      nx_log = '0;
      case (op)
         OP_MUL: begin
            if (a_zero || b_zero) nx_f.zero = 1'b1;
            else begin
               nx_log   = sum_log;
               nx_f.ovf = sum_ovf;
               nx_f.sgn = a_sgn ^ b_sgn;
            end
         end
         OP_DIV: begin
            if (b_zero) begin
               nx_log   = MAXV;
               nx_f.ovf = 1'b1;
               nx_f.sgn = a_sgn ^ b_sgn;
            end else if (a_zero) nx_f.zero = 1'b1;
            else begin
               nx_log   = dif_log;
               nx_f.ovf = dif_ovf;
               nx_f.sgn = a_sgn ^ b_sgn;
            end
         end
         OP_SQR: begin
            if (a_zero) nx_f.zero = 1'b1;
            else begin
               nx_log   = dbl_log;
               nx_f.ovf = dbl_ovf;
            end
         end
         OP_RCP: begin
            nx_f.sgn = a_sgn;
            if (a_zero) begin
               nx_log   = MAXV;
               nx_f.ovf = 1'b1;
            end else begin
               nx_log   = neg_log;
               nx_f.ovf = neg_ovf;
            end
         end
         OP_SQRT: begin
            if (a_zero) nx_f.zero = 1'b1;
            else begin
               nx_log   = half_log;
               nx_f.inv = a_sgn;
            end
         end
         default: begin
            nx_log    = a_log;
            nx_f.sgn  = a_sgn;
            nx_f.zero = a_zero;
         end
      endcase
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               res_sgn  <= 1'b0;
               res_zero <= 1'b0;
               res_log  <= '0;
               res_ovf  <= 1'b0;
               res_inv  <= 1'b0;
            end else begin
               res_sgn  <= nx_f.sgn;
               res_zero <= nx_f.zero;
               res_log  <= nx_log;
               res_ovf  <= nx_f.ovf;
               res_inv  <= nx_f.inv;
            end
         end

         // R2: unclamped product equals the operand log sum
         a_r2_mul_sum: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_i) == 3'd0 && !$past(a_zero) && !$past(b_zero) && !res_ovf)
               |-> res_log == ($past(a_log) + $past(b_log)));

         // R2 / R3: sign of a product or quotient of nonzero operands
         a_r3_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_i) < 3'd2 && !$past(a_zero) && !$past(b_zero))
               |-> res_sgn == ($past(a_sgn) ^ $past(b_sgn)));

         // R6: square root never overflows and flags negative operands
         a_r6_sqrt_flags: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_i) == 3'd4 && !$past(a_zero))
               |-> !res_ovf && res_inv == $past(a_sgn) && !res_sgn);

         // R7: an overflowed result sits on a range end
         a_r7_ovf_clamped: assert property (@(posedge clk) disable iff (!rst_n)
            res_ovf |-> (res_log == MAXV || res_log == ~MAXV));

         // R8: zero results carry no magnitude and no flags
         a_r8_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_i) < 3'd5 && res_zero)
               |-> res_log == '0 && !res_ovf && !res_inv && !res_sgn);

         // R9: division by a zero operand always overflows
         a_r9_div_by_zero: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_i) == 3'd1 && $past(b_zero))
               |-> res_ovf && !res_zero);

         // R10: pass-through opcodes raise no flag
         a_r10_pass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_i) >= 3'd5)
               |-> !res_ovf && !res_inv && res_log == $past(a_log));
      end else begin : g_comb
         assign res_sgn  = nx_f.sgn;
         assign res_zero = nx_f.zero;
         assign res_log  = nx_log;
         assign res_ovf  = nx_f.ovf;
         assign res_inv  = nx_f.inv;
      end
   endgenerate
endmodule

// File: tb/tb_slns_mpu.sv
module tb_slns_mpu;
   localparam int W = 20;
   localparam longint MAXI = (64'sd1 <<< (W-1)) - 1;
   localparam longint MINI = -(64'sd1 <<< (W-1));

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   op_i = '0;
   logic         a_sgn = 0, a_zero = 0, b_sgn = 0, b_zero = 0;
   logic [W-1:0] a_log = '0, b_log = '0;
   logic         res_sgn, res_zero, res_ovf, res_inv;
   logic [W-1:0] res_log;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   slns_mpu #(.LOG_W(W), .FRAC_W(12), .REG_OUT(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i),
      .a_sgn(a_sgn), .a_zero(a_zero), .a_log(a_log),
      .b_sgn(b_sgn), .b_zero(b_zero), .b_log(b_log),
      .res_sgn(res_sgn), .res_zero(res_zero), .res_log(res_log),
      .res_ovf(res_ovf), .res_inv(res_inv));

   function automatic logic [W-1:0] val(input int i);
      longint v;
      case (i)
         0: v = 0;        1: v = 1;         2: v = -1;        3: v = MAXI;
         4: v = MINI;     5: v = MAXI - 1;  6: v = MINI + 1;  7: v = 'h40000;
         8: v = -'h40000; 9: v = 'h3FFFF;   10: v = 'h1000;   11: v = -'h1000;
         12: v = 'h12345; 13: v = -'h2468A; 14: v = 3;        default: v = -3;
      endcase
      return W'(v);
   endfunction

   // packed expected result: {sgn, zero, ovf, inv, log}
   function automatic logic [W+3:0] model(input int op, input logic as, input logic az,
                                          input logic [W-1:0] a, input logic bs,
                                          input logic bz, input logic [W-1:0] b);
      longint A, B, r;
      logic s, z, o, iv;
      A = longint'($signed(a));
      B = longint'($signed(b));
      s = 0; z = 0; o = 0; iv = 0; r = 0;
      case (op)
         0: if (az || bz) z = 1; else begin r = A + B; s = as ^ bs; end
         1: if (bz) begin r = MAXI; o = 1; s = as ^ bs; end
            else if (az) z = 1; else begin r = A - B; s = as ^ bs; end
         2: if (az) z = 1; else r = 2 * A;
         3: begin s = as; if (az) begin r = MAXI; o = 1; end else r = -A; end
         4: if (az) z = 1; else begin r = A >>> 1; iv = as; end
         default: begin r = A; s = as; z = az; end
      endcase
      if (r > MAXI) begin r = MAXI; o = 1; end
      if (r < MINI) begin r = MINI; o = 1; end
      return {s, z, o, iv, W'(r)};
   endfunction

   function automatic string tag(input int op, input logic [W+3:0] e);
      if (op >= 5)            return "R10";
      if (e[W+2])             return "R8";
      if (e[W+1] && op != 4) begin
         if (op == 1 || op == 3) begin
            if (e[W-1:0] == W'(MAXI) && e[W+1]) return (op == 1 ? "R9/R7" : "R9/R5/R7");
         end
         return "R7";
      end
      case (op)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(input string req, input logic [W+3:0] exp);
      logic [W+3:0] got;
      got = {res_sgn, res_zero, res_ovf, res_inv, res_log};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got sgn/zero/ovf/inv/log=%b%b%b%b/%h expected %b%b%b%b/%h",
                  req, got[W+3], got[W+2], got[W+1], got[W], got[W-1:0],
                  exp[W+3], exp[W+2], exp[W+1], exp[W], exp[W-1:0]);
      end
   endtask

   task automatic apply(input int op, input logic as, input logic az, input logic [W-1:0] a,
                        input logic bs, input logic bz, input logic [W-1:0] b, input string req);
      logic [W+3:0] e;
      @(negedge clk);
      op_i = 3'(op); a_sgn = as; a_zero = az; a_log = a;
      b_sgn = bs; b_zero = bz; b_log = b;
      @(negedge clk);
      e = model(op, as, az, a, bs, bz, b);
      check(req.len() == 0 ? tag(op, e) : req, e);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int k;
      logic [W+3:0] held;
      // R1: outputs cleared while reset is held, even with live operands
      op_i = 3'd0; a_log = val(1); b_log = val(1); a_sgn = 1;
      repeat (3) @(negedge clk);
      check("R1 reset", '0);
      rst_n = 1'b1;

      // R1: one-cycle latency, previous result held before the edge
      apply(0, 0, 0, val(10), 0, 0, val(10), "R1/R2");
      held = {res_sgn, res_zero, res_ovf, res_inv, res_log};
      @(negedge clk);
      op_i = 3'd3; a_log = val(12); a_zero = 0;
      #9;
      check("R1 hold", held);
      @(negedge clk);
      check("R1/R5", model(3, a_sgn, 0, val(12), b_sgn, b_zero, b_log));

      // sweep: all opcodes against boundary operand pairs
      k = 0;
      for (int op = 0; op < 8; op++)
         for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++) begin
               apply(op, k[0], (k % 7) == 3, val(i), k[1], (k % 5) == 2, val(j), "");
               k++;
            end

      // targeted corners
      apply(0, 1, 0, val(3), 0, 0, val(3), "R7 mul high clamp");
      apply(0, 0, 0, val(4), 1, 0, val(2), "R7 mul low clamp");
      apply(1, 1, 0, val(3), 0, 0, val(2), "R7 div high clamp");
      apply(2, 0, 0, val(7), 0, 0, 0, "R4/R7 square clamp");
      apply(3, 1, 0, val(4), 0, 0, 0, "R5/R7 negate min");
      apply(4, 1, 0, val(15), 0, 0, 0, "R6 floor and invalid");
      apply(1, 1, 1, val(12), 0, 1, val(3), "R9 zero by zero");
      apply(3, 1, 1, val(12), 0, 0, 0, "R9 reciprocal of zero");
      apply(0, 1, 1, val(12), 1, 0, val(3), "R8 mul zero");
      apply(7, 1, 1, val(13), 0, 0, val(3), "R10 pass zero marker");
      // R11: B fields have no effect on unary results
      for (int op = 2; op < 8; op++)
         for (int j = 0; j < 4; j++) begin
            if (op == 2 || op == 3 || op == 4 || op >= 5)
               apply(op, 1, 0, val(12), j[0], j[1], val(j * 3 + 1), "R11");
         end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule